// File: doc/BRIEF.md
# Pattern-Clocked JTAG Shift Engine

This block drives a four-wire JTAG-style serial link from a host-side register interface. The host does not ask for a number of clocks. It writes the TCK waveform itself as a bit pattern. The engine plays that pattern out one bit per tick of a divided reference clock, so TCK can have any duty cycle the host chooses, including asymmetric pulses. The TMS and TDI output shifters and the TDO capture register do not run from a free clock. They advance on the edges of the generated TCK line: a high-to-low step moves the output shifters on, and a low-to-high step samples TDO.

To use it, the host loads the TMS and TDI words first. It then writes one or more pattern words and carries on with other work while the pattern plays. It uses the busy flag as its synchronisation point. Before a capture, the host clears the TDO register. It then waits for the valid flag, which rises once 32 fresh bits have been captured. A one-word queue lets the host write a second pattern while the first one is still playing, so consecutive words run with no gap between them.

Top module: `jtag_pattern_shifter`

## Requirements
- R1: After reset, tck is 1, tms and tdi are 0, busy is 0, pat_ready is 1 and tdo_valid is 0.
- R2: Each pattern bit holds tck for exactly DIV clk cycles (DIV = 10 by default).
- R3: A pattern word plays least-significant bit first. It plays pat_len_m1 + 1 bits, so the field value 5 means 6 bits and 31 means 32 bits. Each bit sets the tck level for its tick. When no bits are pending, tck returns to 1 at the next tick.
- R4: tms and tdi change only when tck goes from 1 to 0. On each such step, each shifter drives the next bit of its loaded 32-bit word, least-significant bit first. Loading TMS with 1 and playing pattern 101010 (6 bits, LSB first 0,1,0,1,0,1) gives three pulses with tms = 1, 0, 0.
- R5: On each tck step from 0 to 1, tdo is stored into tdo_word at the next bit position, starting at bit 0. tdo_valid rises once 32 bits have been stored. After that, further steps leave tdo_word unchanged.
- R6: A tdo_clear pulse sets tdo_word to 0, empties the bit count and drops tdo_valid on the next cycle.
- R7: pat_ready is 0 while the one-word queue is occupied. Accepted words play back to back with no idle tick between them, so two 0xAAAAAAAA words give 32 equal-width pulses.
- R8: busy is 1 from the cycle after a pattern word is accepted until its last bit has been driven. pat_ready is never 0 while busy is 0.
- R9: Once all 32 loaded bits of a shifter are used, further falling steps keep tms at its last driven value and drive tdi to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms_load | input | 1 | Load tms_wdata into the TMS shifter |
| tms_wdata | input | 32 | TMS word, sent LSB first |
| tdi_load | input | 1 | Load tdi_wdata into the TDI shifter |
| tdi_wdata | input | 32 | TDI word, sent LSB first |
| pat_valid | input | 1 | Pattern word write request |
| pat_data | input | 32 | TCK pattern bits, LSB first |
| pat_len_m1 | input | 5 | Number of pattern bits minus one |
| pat_ready | output | 1 | Queue slot free; a write is taken when valid and ready |
| tdo_clear | input | 1 | Discard captured TDO bits |
| tdo_word | output | 32 | Captured TDO word |
| tdo_valid | output | 1 | 32 bits captured since the last clear |
| busy | output | 1 | Pattern bits still pending |
| tck | output | 1 | Generated TCK line |
| tms | output | 1 | TMS line |
| tdi | output | 1 | TDI line |
| tdo | input | 1 | TDO line from the target |

## Verification
The hardest situation to reach is a queue handover. In that case a second word is taken while the first is playing and must start on the very next tick. The bench reaches it by writing two words back to back and then checking that pat_ready is low and that no tck level lasts longer than one tick. A second hard case is shifter exhaustion. It appears only after a full 32 falling steps, so the bench follows a 32-pulse transfer with a short extra pattern. Random patterns, each forced to end high, are pushed in pairs, and the bench counts their falling steps and compares them with counts computed from the bits.

// File: rtl/jps_pkg.sv
// Shared sizes and types for the pattern-clocked JTAG shift engine.
// Assumes a 32-bit host word; every width below is derived from it.
package jps_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = $clog2(WORD_W);
    localparam int CNT_W  = $clog2(WORD_W + 1);
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/jps_tick_div.sv
// Free-running divider: raises tick_o for one clk cycle out of every DIV.
// Assumes DIV >= 2.
module jps_tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = $clog2(DIV);
    logic [DW-1:0] cnt_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q == DW'(DIV - 1))      cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == DW'(DIV - 1));
endmodule

// File: rtl/jps_tck_gen.sv
// Plays host-written TCK patterns LSB first, one bit per tick, and drives TCK
// high when nothing is pending. It holds one active word and one queued word.
// It reports the falling and rising steps of TCK as one-cycle strobes.
// Assumes tick_i is a single-cycle enable.
module jps_tck_gen #(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 wvalid_i,
    input  logic [W-1:0]         wdata_i,
    input  logic [$clog2(W)-1:0] wlen_m1_i,
    output logic                 wready_o,
    output logic                 tck_o,
    output logic                 fall_o,
    output logic                 rise_o,
    output logic                 busy_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  cur_q, que_q;
    logic [CW-1:0] cur_cnt_q, que_cnt_q;
    logic          que_vld_q, tck_q, tck_nxt;

    // Next TCK level: the current pattern bit on a tick, else idle high.
    always_comb begin
        tck_nxt = tck_q;
        if (tick_i) tck_nxt = (cur_cnt_q != '0) ? cur_q[0] : 1'b1;
    end

    // Register the TCK line.
    always_ff @(posedge clk) begin
        if (!rst_n) tck_q <= 1'b1;
        else        tck_q <= tck_nxt;
    end

    // Active shifter: consume a bit per tick; take the queued word on the
    // last bit or when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_cnt_q <= '0;
        end else if (tick_i && cur_cnt_q != '0) begin
            if (cur_cnt_q == CW'(1) && que_vld_q) begin
                cur_q     <= que_q;
                cur_cnt_q <= que_cnt_q;
            end else begin
                cur_q     <= cur_q >> 1;
                cur_cnt_q <= cur_cnt_q - 1'b1;
            end
        end else if (cur_cnt_q == '0 && que_vld_q) begin
            cur_q     <= que_q;
            cur_cnt_q <= que_cnt_q;
        end
    end

    // Queue slot: fill on an accepted write, empty when the active side takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            que_q     <= '0;
            que_cnt_q <= '0;
            que_vld_q <= 1'b0;
        end else if (wvalid_i && !que_vld_q) begin
            que_q     <= wdata_i;
            que_cnt_q <= CW'(wlen_m1_i) + CW'(1);
            que_vld_q <= 1'b1;
        end else if (que_vld_q && (cur_cnt_q == '0 ||
                     (tick_i && cur_cnt_q == CW'(1)))) begin
            que_vld_q <= 1'b0;
        end
    end

    assign wready_o = !que_vld_q;
    assign busy_o   = (cur_cnt_q != '0) || que_vld_q;
    assign tck_o    = tck_q;
    assign fall_o   = tck_q & ~tck_nxt;
    assign rise_o   = ~tck_q & tck_nxt;
endmodule

// File: rtl/jps_out_shift.sv
// Serial output shifter advanced by TCK falling-step strobes, LSB first.
// When its loaded bits are used up it either holds the last bit (HOLD_LAST=1)
// or drives 0. Assumes the host loads before issuing the matching pattern;
// a load in the same cycle as an advance wins.
module jps_out_shift #(
    parameter int W         = 32,
    parameter bit HOLD_LAST = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         adv_i,
    output logic         bit_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          bit_q, spent_bit;

    // Choose the value driven once the shifter is empty.
    generate
        if (HOLD_LAST) begin : g_hold
            assign spent_bit = bit_q;
        end else begin : g_zero
            assign spent_bit = 1'b0;
        end
    endgenerate

    // Load a word, or move one bit to the line on each falling step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
            bit_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= data_i;
            cnt_q <= CW'(W);
        end else if (adv_i) begin
            if (cnt_q != '0) begin
                bit_q <= sh_q[0];
                sh_q  <= sh_q >> 1;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                bit_q <= spent_bit;
            end
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/jps_tdo_cap.sv
// Captures TDO on TCK rising-step strobes into a word, filling from bit 0 up.
// It stops after W bits until cleared. Assumes tdo_i is stable around the strobe.
module jps_tdo_cap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         rise_i,
    input  logic         tdo_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    localparam int CW = $clog2(W + 1);
    localparam int IW = $clog2(W);

    logic [W-1:0]  word_q;
    logic [CW-1:0] cnt_q;

    // Clear, or store one sample per rising step until full.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (rise_i && cnt_q != CW'(W)) begin
            word_q[cnt_q[IW-1:0]] <= tdo_i;
            cnt_q                 <= cnt_q + 1'b1;
        end
    end

    assign word_o  = word_q;
    assign valid_o = (cnt_q == CW'(W));
endmodule

// File: rtl/jtag_pattern_shifter.sv
// Top of the pattern-clocked JTAG shift engine. TCK is a host-written
// bit pattern played at clk/DIV. TMS and TDI advance on TCK falling steps,
// and TDO is sampled on TCK rising steps. All logic runs on clk; TCK edges
// are one-cycle strobes, not clocks.
module jtag_pattern_shifter
    import jps_pkg::*;
#(
    parameter int DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tms_load,
    input  logic [WORD_W-1:0] tms_wdata,
    input  logic             tdi_load,
    input  logic [WORD_W-1:0] tdi_wdata,
    input  logic             pat_valid,
    input  logic [WORD_W-1:0] pat_data,
    input  logic [LEN_W-1:0] pat_len_m1,
    output logic             pat_ready,
    input  logic             tdo_clear,
    output logic [WORD_W-1:0] tdo_word,
    output logic             tdo_valid,
    output logic             busy,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo
);
    logic tick, tck_fall, tck_rise;

    jps_tick_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    jps_tck_gen #(.W(WORD_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .wvalid_i(pat_valid), .wdata_i(pat_data), .wlen_m1_i(pat_len_m1),
        .wready_o(pat_ready), .tck_o(tck), .fall_o(tck_fall),
        .rise_o(tck_rise), .busy_o(busy)
    );

    jps_out_shift #(.W(WORD_W), .HOLD_LAST(1'b1)) u_tms (
        .clk(clk), .rst_n(rst_n), .load_i(tms_load), .data_i(tms_wdata),
        .adv_i(tck_fall), .bit_o(tms)
    );

    jps_out_shift #(.W(WORD_W), .HOLD_LAST(1'b0)) u_tdi (
        .clk(clk), .rst_n(rst_n), .load_i(tdi_load), .data_i(tdi_wdata),
        .adv_i(tck_fall), .bit_o(tdi)
    );

    jps_tdo_cap #(.W(WORD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear_i(tdo_clear), .rise_i(tck_rise),
        .tdo_i(tdo), .word_o(tdo_word), .valid_o(tdo_valid)
    );
endmodule

// File: rtl/jps_checker.sv
// Protocol checker for jtag_pattern_shifter, attached by bind below.
// Assumes the top-level tick signal is visible as an internal net.
module jps_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         tck,
    input logic         tms,
    input logic         tdi,
    input logic         busy,
    input logic         pat_valid,
    input logic         pat_ready,
    input logic         tdo_clear,
    input logic         tdo_valid,
    input logic [W-1:0] tdo_word
);
    // R2: TCK moves only on a divider tick.
    a_r2_tck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tck));

    // R3: with nothing pending, a tick leaves TCK high.
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy) |=> tck);

    // R4: data lines move only on a tick.
    a_r4_data_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(tms) && $stable(tdi)));

    // R4: no falling step is possible while idle and high, so data holds.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && !busy) |=> ($stable(tms) && $stable(tdi)));

    // R8: a full queue implies pending work.
    a_r8_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !pat_ready |-> busy);

    // R7: an accepted word makes the engine busy.
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_valid && pat_ready) |=> busy);

    // R5: a complete capture stays put until cleared.
    a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tdo_valid && !tdo_clear) |=> (tdo_valid && $stable(tdo_word)));

    // R6: clearing empties the capture.
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tdo_clear |=> (!tdo_valid && tdo_word == '0));
endmodule

bind jtag_pattern_shifter jps_checker #(.W(jps_pkg::WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tck(tck), .tms(tms), .tdi(tdi),
    .busy(busy), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .tdo_clear(tdo_clear), .tdo_valid(tdo_valid), .tdo_word(tdo_word)
);

// File: tb/jtag_pattern_shifter_tb.sv
module jtag_pattern_shifter_tb;
    localparam int DIV = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tms_load = 0, tdi_load = 0, pat_valid = 0, tdo_clear = 0;
    logic [31:0] tms_wdata = '0, tdi_wdata = '0, pat_data = '0;
    logic [4:0]  pat_len_m1 = '0;
    logic        pat_ready, tdo_valid, busy, tck, tms, tdi, tdo;
    logic [31:0] tdo_word;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Bench-side view of the line activity.
    int   nfall, nrise, cyc, last_chg, max_hold, fall_cyc, low_len;
    logic fall_tms [64];
    logic fall_tdi [64];
    logic [63:0] tdo_src = '0;
    logic tck_prev;

    always #2 clk = ~clk;

    assign tdo = tdo_src[nrise[5:0]];

    jtag_pattern_shifter #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tms_load(tms_load), .tms_wdata(tms_wdata),
        .tdi_load(tdi_load), .tdi_wdata(tdi_wdata), .pat_valid(pat_valid),
        .pat_data(pat_data), .pat_len_m1(pat_len_m1), .pat_ready(pat_ready),
        .tdo_clear(tdo_clear), .tdo_word(tdo_word), .tdo_valid(tdo_valid),
        .busy(busy), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    // Monitor: sample the lines at the falling clk edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && tck !== tck_prev) begin
            if (last_chg >= 0 && cyc - last_chg > max_hold) max_hold = cyc - last_chg;
            last_chg = cyc;
            if (!tck) begin
                if (nfall < 64) begin
                    fall_tms[nfall] = tms;
                    fall_tdi[nfall] = tdi;
                end
                nfall = nfall + 1;
                fall_cyc = cyc;
            end else begin
                nrise = nrise + 1;
                low_len = cyc - fall_cyc;
            end
        end
        tck_prev = tck;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mon_reset();
        nfall = 0; nrise = 0; last_chg = -1; max_hold = 0; low_len = 0;
    endtask

    task automatic push(input logic [31:0] d, input logic [4:0] lm1);
        @(negedge clk);
        while (!pat_ready) @(negedge clk);
        pat_data = d; pat_len_m1 = lm1; pat_valid = 1;
        @(negedge clk);
        pat_valid = 0;
    endtask

    task automatic load_both(input logic [31:0] m, input logic [31:0] i);
        @(negedge clk);
        tms_wdata = m; tdi_wdata = i; tms_load = 1; tdi_load = 1;
        @(negedge clk);
        tms_load = 0; tdi_load = 0;
    endtask

    task automatic clear_cap();
        @(negedge clk);
        tdo_clear = 1;
        @(negedge clk);
        tdo_clear = 0;
        nrise = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (DIV + 2) @(negedge clk);
    endtask

    // Falling steps of a pattern, starting from a given level.
    function automatic int exp_falls(input logic [31:0] d, input int len, input logic start);
        logic lvl = start;
        int   c = 0;
        for (int i = 0; i < len; i++) begin
            if (lvl && !d[i]) c++;
            lvl = d[i];
        end
        return c;
    endfunction

    // Compare recorded data bits at falls against a loaded word from offset 0.
    function automatic int data_miss(input logic [31:0] w, input int n, input bit is_tms);
        int m = 0;
        for (int k = 0; k < n; k++) begin
            if ((is_tms ? fall_tms[k] : fall_tdi[k]) !== w[k]) m++;
        end
        return m;
    endfunction

    initial begin
        logic [31:0] mw, iw, p1, p2;
        int l1, l2, ef, miss;
        void'($urandom(32'h5eed_1234));
        mon_reset(); cyc = 0; tck_prev = 1'b1; fall_cyc = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(tck === 1 && tms === 0 && tdi === 0, "R1", "lines after reset",
              {tck, tms, tdi}, 3'b100);
        check(busy === 0 && pat_ready === 1 && tdo_valid === 0, "R1", "status after reset",
              {busy, pat_ready, tdo_valid}, 3'b010);

        // R4 directed: TMS 0001 with pattern 101010 (6 bits)
        load_both(32'h1, 32'h0);
        mon_reset();
        push(32'b101010, 5'd5);
        check(busy === 1, "R8", "busy while playing", busy, 1);
        wait_idle();
        check(nfall == 3, "R4", "pulse count 101010", nfall, 3);
        check({fall_tms[0], fall_tms[1], fall_tms[2]} == 3'b100, "R4", "tms sequence",
              {fall_tms[0], fall_tms[1], fall_tms[2]}, 3'b100);
        check(low_len == DIV, "R2", "low time per bit", low_len, DIV);
        check(tck === 1 && busy === 0, "R3", "idle high after pattern", {tck, busy}, 2'b10);

        // R5/R7 full 32-bit transfer with two back-to-back words
        mw = $urandom(); iw = $urandom();
        tdo_src = {$urandom(), $urandom()};
        clear_cap();
        load_both(mw, iw);
        mon_reset();
        push(32'hAAAA_AAAA, 5'd31);
        push(32'hAAAA_AAAA, 5'd31);
        check(pat_ready === 0, "R7", "queue full after two words", pat_ready, 0);
        for (int t = 0; t < 2000 && !tdo_valid; t++) @(negedge clk);
        wait_idle();
        check(tdo_valid === 1, "R5", "valid after 32 rises", tdo_valid, 1);
        check(tdo_word === tdo_src[31:0], "R5", "captured word", tdo_word, tdo_src[31:0]);
        check(nfall == 32, "R7", "32 pulses from two words", nfall, 32);
        check(max_hold == DIV, "R7", "no gap between words", max_hold, DIV);
        check(data_miss(iw, 32, 0) == 0, "R4", "tdi bits LSB first", data_miss(iw, 32, 0), 0);
        check(data_miss(mw, 32, 1) == 0, "R4", "tms bits LSB first", data_miss(mw, 32, 1), 0);

        // R9 exhausted shifters; R5 extra rises ignored
        mon_reset();
        push(32'b1010, 5'd3);
        wait_idle();
        check(nfall == 2, "R9", "pulses after exhaustion", nfall, 2);
        check(fall_tdi[0] === 0 && fall_tdi[1] === 0, "R9", "tdi zero when spent",
              {fall_tdi[0], fall_tdi[1]}, 0);
        check(fall_tms[0] === mw[31] && fall_tms[1] === mw[31], "R9", "tms holds last",
              {fall_tms[0], fall_tms[1]}, {mw[31], mw[31]});
        check(tdo_valid === 1 && tdo_word === tdo_src[31:0], "R5", "extra rises ignored",
              tdo_word, tdo_src[31:0]);

        // R6 clear discards a partial capture
        clear_cap();
        check(tdo_valid === 0 && tdo_word === 0, "R6", "clear empties", tdo_word, 0);
        push(32'hAAAA, 5'd15);
        wait_idle();
        check(tdo_valid === 0, "R5", "not valid after 8 rises", tdo_valid, 0);
        tdo_src = {$urandom(), $urandom()};
        clear_cap();
        push(32'hAAAA_AAAA, 5'd31);
        push(32'hAAAA_AAAA, 5'd31);
        wait_idle();
        check(tdo_word === tdo_src[31:0], "R6", "capture after clear", tdo_word, tdo_src[31:0]);

        // R3/R4/R7 random pattern pairs, each forced to end high
        for (int it = 0; it < 24; it++) begin
            mw = $urandom(); iw = $urandom();
            l1 = 1 + ($urandom() % 32); l2 = 1 + ($urandom() % 32);
            p1 = $urandom(); p2 = $urandom();
            p1[l1-1] = 1'b1; p2[l2-1] = 1'b1;
            if (exp_falls(p1, l1, 1) + exp_falls(p2, l2, 1) > 32) begin
                p2 = '1;
            end
            ef = exp_falls(p1, l1, 1) + exp_falls(p2, l2, 1);
            load_both(mw, iw);
            mon_reset();
            push(p1, 5'(l1 - 1));
            push(p2, 5'(l2 - 1));
            wait_idle();
            check(nfall == ef, "R3", "random falling-step count", nfall, ef);
            miss = data_miss(mw, ef, 1) + data_miss(iw, ef, 0);
            check(miss == 0, "R4", "random data bits at falls", miss, 0);
            check(tck === 1, "R3", "idle high after random pair", tck, 1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule